// File: doc/BRIEF.md
# Switch Packet Routing Verdict Unit

This unit sits beside one port of a small packet switch that has a single upstream port (port 0) and `NPORT-1` downstream ports. For each decoded transaction-layer header presented with a valid strobe, it returns a verdict and an egress port. The verdict says whether the packet is accepted and routed, refused as an unsupported request, reported as an unexpected completion, or discarded without any error. The unit works only on decoded header fields, the ingress port number, and the per-port routing configuration. That configuration is an address window, a secondary/subordinate bus range, memory, I/O and bus-master enables, and one global bit that turns off the device-zero check.

Memory and I/O requests are routed by address. Configuration requests, completions and ID-routed messages are routed by bus number. Each packet class has its own set of refusal rules: loopback, no route, disabled target, disabled bus mastering, a downstream-originated configuration request, a nonexistent bridge device, and packets that end inside the switch.

Top module: `tlp_route_check`

## Requirements
- R1: One cycle after `hdr_valid` is sampled high, `out_vld` is high and `verdict`/`egress` hold the result for that header. When `hdr_valid` is low, `out_vld` is low on the next cycle and `verdict`/`egress` keep their values. `egress` is 0 whenever `verdict` is not 00. Verdict codes: 00 accept, 01 unsupported request (UR), 10 unexpected completion, 11 silent drop. Reset clears all outputs.
- R2: A memory (kind 0) or I/O (kind 1) request whose address hits the window of its own ingress port gets UR. A downstream port `p` hits when `win_base[p] <= addr <= win_limit[p]`, and the lowest such port wins.
- R3: A memory or I/O request from port 0 gets UR when it lies outside port 0's window, or inside it but in no downstream window. A downstream-originated request that misses every downstream window but lies inside port 0's window also gets UR. One outside port 0's window is routed to port 0.
- R4: A request routed to downstream port `t` gets UR unless `mem_en[t]` is set (memory) or `io_en[t]` is set (I/O).
- R5: A memory or I/O request from downstream port `d` gets UR when `bm_en[d]` is clear. One routed to port 0 gets UR when `bm_en[0]` is clear.
- R6: Every configuration request (kind 2 = Type 0, kind 3 = Type 1) that enters on a downstream port gets UR. A Type 0 request entering on port 0 is accepted with egress 0.
- R7: A Type 1 request from port 0 addressed to bus `sec_bus[0]` (the internal bus) is accepted with egress `dev+1` when `dev < NPORT-1`, and otherwise gets UR. Downstream port `p` is device `p-1` on that bus. A bus that lies in no downstream range gets UR.
- R8: A Type 1 request from port 0 whose bus equals `sec_bus[t]` gets UR when `dev != 0`, unless `dev0_chk_off` is set. Otherwise it is accepted with egress `t`. A bus strictly inside `(sec_bus[t], sub_bus[t]]` is accepted with egress `t`.
- R9: A completion (kind 4) whose bus equals `up_bus` or `sec_bus[0]` gets verdict 10.
- R10: Any other completion is routed to the lowest downstream port whose range contains the bus. Failing that, it goes to port 0 when the bus is outside `[sec_bus[0], sub_bus[0]]`. If that route equals the ingress port, or no route exists, it gets UR.
- R11: An ID-routed message (kind 5) to `up_bus` or to `sec_bus[0]` gets UR when it names device `>= NPORT-1` on the internal bus. Otherwise it is dropped (11) when `msg_vendor` is set and gets UR when it is not. Other messages follow the R10 route and loopback rules.
- R12: A message with `msg_vendor` clear that enters on port 0 and is not addressed to a switch port gets UR.
- R13: Kind codes 6 and 7 get UR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hdr_valid | input | 1 | header fields valid this cycle |
| hdr_kind | input | 3 | packet class code |
| hdr_addr | input | AW | request address |
| hdr_bus | input | 8 | target bus number |
| hdr_dev | input | 5 | target device number |
| msg_vendor | input | 1 | message is vendor-defined |
| ing_port | input | PW | ingress port, 0 = upstream |
| win_base | input | NPORT*AW | per-port window base, port p at [p*AW +: AW] |
| win_limit | input | NPORT*AW | per-port window limit |
| up_bus | input | 8 | bus number of the upstream link |
| sec_bus | input | NPORT*8 | per-port secondary bus |
| sub_bus | input | NPORT*8 | per-port subordinate bus |
| mem_en | input | NPORT | memory access enables |
| io_en | input | NPORT | I/O access enables |
| bm_en | input | NPORT | bus master enables |
| dev0_chk_off | input | 1 | disables the device-zero check |
| out_vld | output | 1 | verdict valid |
| verdict | output | 2 | verdict code |
| egress | output | PW | egress port |

## Verification
The bench targets packets that would loop back onto their ingress port. A design that checked only for a window hit would forward these to the wrong link. It probes the gap inside the upstream window that no downstream port claims, which a naive decoder would send to port 0. It clears one enable bit at a time, so that a design mixing up the memory, I/O and bus-master enables accepts a packet it should refuse. It covers the device-zero check both enabled and disabled, the internal-bus device range edge, and vendor-defined versus standard messages to switch ports. Swapping drop and UR there, or leaking the message upstream, shows up as a wrong code.

// File: rtl/tlp_route_check.sv
module tlp_route_check #(
  parameter int NPORT = 4,
  parameter int AW    = 32,
  localparam int PW   = $clog2(NPORT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_valid,
  input  logic [2:0]          hdr_kind,
  input  logic [AW-1:0]       hdr_addr,
  input  logic [7:0]          hdr_bus,
  input  logic [4:0]          hdr_dev,
  input  logic                msg_vendor,
  input  logic [PW-1:0]       ing_port,
  input  logic [NPORT*AW-1:0] win_base,
  input  logic [NPORT*AW-1:0] win_limit,
  input  logic [7:0]          up_bus,
  input  logic [NPORT*8-1:0]  sec_bus,
  input  logic [NPORT*8-1:0]  sub_bus,
  input  logic [NPORT-1:0]    mem_en,
  input  logic [NPORT-1:0]    io_en,
  input  logic [NPORT-1:0]    bm_en,
  input  logic                dev0_chk_off,
  output logic                out_vld,
  output logic [1:0]          verdict,
  output logic [PW-1:0]       egress
);
  localparam logic [2:0] K_MEM = 3'd0, K_IO = 3'd1, K_CFG0 = 3'd2,
                         K_CFG1 = 3'd3, K_CPL = 3'd4, K_MSG = 3'd5;
  localparam logic [1:0] V_ACC = 2'b00, V_UR = 2'b01, V_UC = 2'b10, V_DROP = 2'b11;
  localparam logic [4:0] NDEV = 5'(NPORT - 1);

  logic [NPORT-1:0] a_hit, b_in, b_sec;
  logic [PW-1:0]    a_idx, b_idx, tgt;
  logic             a_dn, b_dn;
  logic [1:0]       v_n;
  logic [PW-1:0]    e_n;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign a_hit[p] = (hdr_addr >= win_base[p*AW +: AW]) && (hdr_addr <= win_limit[p*AW +: AW]);
    assign b_in[p]  = (hdr_bus >= sec_bus[p*8 +: 8]) && (hdr_bus <= sub_bus[p*8 +: 8]);
    assign b_sec[p] = (hdr_bus == sec_bus[p*8 +: 8]);
  end

  always_comb begin
    a_idx = '0; b_idx = '0; a_dn = 1'b0; b_dn = 1'b0;
    for (int p = NPORT - 1; p >= 1; p--) begin
      if (a_hit[p]) begin a_idx = PW'(p); a_dn = 1'b1; end
      if (b_in[p])  begin b_idx = PW'(p); b_dn = 1'b1; end
    end
  end

  wire to_switch = (hdr_bus == up_bus) || b_sec[0];
  wire id_noroute = !b_dn && b_in[0];
  wire [PW-1:0] id_tgt = b_dn ? b_idx : '0;

  always_comb begin
    v_n = V_UR;
    e_n = '0;
    tgt = a_dn ? a_idx : '0;
    case (hdr_kind)
      K_MEM, K_IO: begin
        if (ing_port != '0 && !bm_en[ing_port])            v_n = V_UR;
        else if (ing_port == '0 && (!a_hit[0] || !a_dn))   v_n = V_UR;
        else if (ing_port != '0 && !a_dn && a_hit[0])      v_n = V_UR;
        else if (tgt == ing_port)                           v_n = V_UR;
        else if (tgt != '0 && !((hdr_kind == K_MEM) ? mem_en[tgt] : io_en[tgt])) v_n = V_UR;
        else if (tgt == '0 && !bm_en[0])                    v_n = V_UR;
        else begin v_n = V_ACC; e_n = tgt; end
      end
      K_CFG0: if (ing_port == '0) v_n = V_ACC;
      K_CFG1: begin
        if (ing_port != '0) v_n = V_UR;
        else if (b_sec[0]) begin
          if (hdr_dev < NDEV) begin v_n = V_ACC; e_n = PW'(hdr_dev) + PW'(1); end
        end else if (b_dn) begin
          if (b_sec[b_idx] && hdr_dev != 5'd0 && !dev0_chk_off) v_n = V_UR;
          else begin v_n = V_ACC; e_n = b_idx; end
        end
      end
      K_CPL: begin
        if (to_switch) v_n = V_UC;
        else if (!id_noroute && id_tgt != ing_port) begin v_n = V_ACC; e_n = id_tgt; end
      end
      K_MSG: begin
        if (to_switch) begin
          if (b_sec[0] && hdr_dev >= NDEV) v_n = V_UR;
          else if (msg_vendor)             v_n = V_DROP;
        end else if (ing_port == '0 && !msg_vendor) v_n = V_UR;
        else if (!id_noroute && id_tgt != ing_port) begin v_n = V_ACC; e_n = id_tgt; end
      end
      default: v_n = V_UR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      verdict <= V_ACC;
      egress  <= '0;
    end else begin
      out_vld <= hdr_valid;
      if (hdr_valid) begin
        verdict <= v_n;
        egress  <= e_n;
      end
    end
  end
endmodule

module tlp_route_check_sva #(
  parameter int NPORT = 4,
  localparam int PW   = $clog2(NPORT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [2:0]       hdr_kind,
  input logic             msg_vendor,
  input logic [PW-1:0]    ing_port,
  input logic [NPORT-1:0] mem_en,
  input logic [NPORT-1:0] bm_en,
  input logic             out_vld,
  input logic [1:0]       verdict,
  input logic [PW-1:0]    egress
);
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> out_vld);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> (!out_vld && $stable(verdict) && $stable(egress)));
  p_egress_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != 2'b00) |-> (egress == '0));
  p_no_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && verdict == 2'b00 && ($past(hdr_kind) inside {3'd0, 3'd1, 3'd4, 3'd5}))
      |-> (egress != $past(ing_port)));
  p_mem_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && verdict == 2'b00 && $past(hdr_kind) == 3'd0 && egress != '0)
      |-> ((($past(mem_en) >> egress) & 1) != 0));
  p_bm_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && verdict == 2'b00 && $past(hdr_kind) inside {3'd0, 3'd1} && $past(ing_port) != '0)
      |-> ((($past(bm_en) >> $past(ing_port)) & 1) != 0));
  p_cfg_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(hdr_kind) inside {3'd2, 3'd3} && $past(ing_port) != '0) |-> (verdict == 2'b01));
  p_uc_only_cpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && verdict == 2'b10) |-> ($past(hdr_kind) == 3'd4));
  p_drop_vendor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && verdict == 2'b11) |-> ($past(hdr_kind) == 3'd5 && $past(msg_vendor)));
  p_unused_kind_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(hdr_kind) > 3'd5) |-> (verdict == 2'b01));
endmodule

bind tlp_route_check tlp_route_check_sva #(.NPORT(NPORT)) u_sva (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
  .msg_vendor(msg_vendor), .ing_port(ing_port), .mem_en(mem_en), .bm_en(bm_en),
  .out_vld(out_vld), .verdict(verdict), .egress(egress)
);

// File: tb/tlp_route_check_test.sv
module tlp_route_check_test;
  localparam int NPORT = 4;
  localparam int AW = 32;
  localparam int PW = 2;

  logic clk = 1'b0, rst_n = 1'b0, hdr_valid = 1'b0;
  logic [2:0] hdr_kind = '0;
  logic [AW-1:0] hdr_addr = '0;
  logic [7:0] hdr_bus = '0;
  logic [4:0] hdr_dev = '0;
  logic msg_vendor = 1'b0;
  logic [PW-1:0] ing_port = '0;
  logic [NPORT*AW-1:0] win_base, win_limit;
  logic [7:0] up_bus;
  logic [NPORT*8-1:0] sec_bus, sub_bus;
  logic [NPORT-1:0] mem_en = '1, io_en = '1, bm_en = '1;
  logic dev0_chk_off = 1'b0;
  logic out_vld;
  logic [1:0] verdict;
  logic [PW-1:0] egress;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tlp_route_check #(.NPORT(NPORT), .AW(AW)) uut (.*);

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  ing;
    logic [31:0] addr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic        ven;
    logic [1:0]  v;
    logic [1:0]  e;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 32'h1080_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd1},  // R4 mem to port1
    '{3'd0, 2'd0, 32'h1180_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd2},  // R4
    '{3'd1, 2'd0, 32'h1280_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd3},  // R4 io
    '{3'd0, 2'd0, 32'h1500_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0},  // R3 gap
    '{3'd0, 2'd0, 32'h3000_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0},  // R3 outside
    '{3'd0, 2'd1, 32'h1080_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0},  // R2 loopback
    '{3'd0, 2'd1, 32'h1180_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd2},  // R2 peer
    '{3'd0, 2'd2, 32'h4000_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd0},  // R3 up
    '{3'd0, 2'd2, 32'h1500_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0},  // R3 gap from dn
    '{3'd2, 2'd1, 32'h0,         8'd3, 5'd0, 1'b0, 2'd1, 2'd0},  // R6
    '{3'd3, 2'd2, 32'h0,         8'd7, 5'd0, 1'b0, 2'd1, 2'd0},  // R6
    '{3'd2, 2'd0, 32'h0,         8'd1, 5'd0, 1'b0, 2'd0, 2'd0},  // R6 t0 upstream
    '{3'd3, 2'd0, 32'h0,         8'd2, 5'd1, 1'b0, 2'd0, 2'd2},  // R7
    '{3'd3, 2'd0, 32'h0,         8'd2, 5'd3, 1'b0, 2'd1, 2'd0},  // R7 edge
    '{3'd3, 2'd0, 32'h0,         8'd6, 5'd0, 1'b0, 2'd0, 2'd2},  // R8
    '{3'd3, 2'd0, 32'h0,         8'd6, 5'd4, 1'b0, 2'd1, 2'd0},  // R8
    '{3'd3, 2'd0, 32'h0,         8'd7, 5'd4, 1'b0, 2'd0, 2'd2},  // R8 pass-through
    '{3'd3, 2'd0, 32'h0,         8'd30, 5'd0, 1'b0, 2'd1, 2'd0}, // R7 no range
    '{3'd4, 2'd0, 32'h0,         8'd8, 5'd0, 1'b0, 2'd0, 2'd2},  // R10
    '{3'd4, 2'd2, 32'h0,         8'd8, 5'd0, 1'b0, 2'd1, 2'd0},  // R10 loop
    '{3'd4, 2'd3, 32'h0,         8'd50, 5'd0, 1'b0, 2'd0, 2'd0}, // R10 up
    '{3'd4, 2'd0, 32'h0,         8'd50, 5'd0, 1'b0, 2'd1, 2'd0}, // R10 loop up
    '{3'd4, 2'd1, 32'h0,         8'd1, 5'd0, 1'b0, 2'd2, 2'd0},  // R9
    '{3'd4, 2'd0, 32'h0,         8'd2, 5'd0, 1'b0, 2'd2, 2'd0},  // R9
    '{3'd5, 2'd0, 32'h0,         8'd4, 5'd0, 1'b1, 2'd0, 2'd1},  // R11
    '{3'd5, 2'd1, 32'h0,         8'd2, 5'd0, 1'b1, 2'd3, 2'd0},  // R11 drop
    '{3'd5, 2'd1, 32'h0,         8'd2, 5'd1, 1'b0, 2'd1, 2'd0},  // R11
    '{3'd5, 2'd1, 32'h0,         8'd2, 5'd5, 1'b1, 2'd1, 2'd0},  // R11 no dev
    '{3'd5, 2'd0, 32'h0,         8'd4, 5'd0, 1'b0, 2'd1, 2'd0},  // R12
    '{3'd5, 2'd3, 32'h0,         8'd4, 5'd0, 1'b0, 2'd0, 2'd1},  // R11
    '{3'd5, 2'd1, 32'h0,         8'd4, 5'd0, 1'b1, 2'd1, 2'd0},  // R11 loop
    '{3'd5, 2'd1, 32'h0,         8'd1, 5'd0, 1'b1, 2'd3, 2'd0},  // R11 drop up_bus
    '{3'd6, 2'd0, 32'h1080_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0}   // R13
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t t, string tag);
    @(negedge clk);
    hdr_kind = t.kind; ing_port = t.ing; hdr_addr = t.addr;
    hdr_bus = t.bus; hdr_dev = t.dev; msg_vendor = t.ven; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check({tag, " vld"}, 32'(out_vld), 32'd1);
    check({tag, " verdict"}, 32'(verdict), 32'(t.v));
    check({tag, " egress"}, 32'(egress), 32'(t.e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    win_base  = {32'h1200_0000, 32'h1100_0000, 32'h1000_0000, 32'h1000_0000};
    win_limit = {32'h12FF_FFFF, 32'h11FF_FFFF, 32'h10FF_FFFF, 32'h1FFF_FFFF};
    up_bus  = 8'd1;
    sec_bus = {8'd11, 8'd6, 8'd3, 8'd2};
    sub_bus = {8'd20, 8'd10, 8'd5, 8'd20};
    repeat (3) @(negedge clk);
    check("R1 reset vld", 32'(out_vld), 32'd0);
    check("R1 reset verdict", 32'(verdict), 32'd0);
    check("R1 reset egress", 32'(egress), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i], $sformatf("vec%0d", i));

    // R1: no strobe -> vld low, outputs hold the last result
    apply('{3'd0, 2'd0, 32'h1180_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd2}, "R1 setup");
    hdr_addr = 32'h1500_0000;
    @(negedge clk);
    check("R1 idle vld", 32'(out_vld), 32'd0);
    check("R1 hold verdict", 32'(verdict), 32'd0);
    check("R1 hold egress", 32'(egress), 32'd2);

    // R4 enable gating
    mem_en[2] = 1'b0;
    apply('{3'd0, 2'd0, 32'h1180_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0}, "R4 mem_en off");
    apply('{3'd1, 2'd0, 32'h1180_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd2}, "R4 io unaffected");
    mem_en[2] = 1'b1; io_en[3] = 1'b0;
    apply('{3'd1, 2'd0, 32'h1280_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0}, "R4 io_en off");
    apply('{3'd0, 2'd0, 32'h1280_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd3}, "R4 mem unaffected");
    io_en[3] = 1'b1;

    // R5 bus master gating
    bm_en[2] = 1'b0;
    apply('{3'd0, 2'd2, 32'h1080_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0}, "R5 ingress bm off");
    apply('{3'd0, 2'd3, 32'h1080_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd1}, "R5 other ingress");
    bm_en[2] = 1'b1; bm_en[0] = 1'b0;
    apply('{3'd0, 2'd2, 32'h4000_0000, 8'd0, 5'd0, 1'b0, 2'd1, 2'd0}, "R5 upstream bm off");
    apply('{3'd1, 2'd2, 32'h1280_0000, 8'd0, 5'd0, 1'b0, 2'd0, 2'd3}, "R5 peer ok");
    bm_en[0] = 1'b1;

    // R8 device-zero check disabled
    dev0_chk_off = 1'b1;
    apply('{3'd3, 2'd0, 32'h0, 8'd6, 5'd4, 1'b0, 2'd0, 2'd2}, "R8 check off");
    dev0_chk_off = 1'b0;
    apply('{3'd3, 2'd0, 32'h0, 8'd11, 5'd2, 1'b0, 2'd1, 2'd0}, "R8 check on");

    // R13 kind 7
    apply('{3'd7, 2'd0, 32'h0, 8'd4, 5'd0, 1'b1, 2'd1, 2'd0}, "R13 kind7");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule